// File: doc/BRIEF.md
# Pipelined Membership Set with Counting Summary Tree

This block keeps a set of elements drawn from a fixed universe of `NUM_ELEM` members as a bitmap. The bitmap is cut into leaf words of `WORD_W` bits each. Above the leaves sits a binary tree of summary nodes. Every node stores two occupancy counts: the number of set bits below its left child and the number below its right child. Four operations are available. Insert sets a member's bit. Remove clears it. Query reports whether a member is present. Locate returns a member that is present, or reports that the set is empty. Locate uses the counts to walk straight down to a set bit, taking one step per tree level.

Each tree level and the leaf words sit in private storage banks. An operation moves through the levels top-down, one level per pipeline stage. So up to `LEV+1` operations can be active at once, each on a different level, and a new operation can be accepted on every clock. An operation's pre-state membership comes from the leaf storage, overridden by any older insert or remove on the same element that is still in the pipeline. Results leave in the order the operations were issued.

Top module: `abt_set`

## Requirements
- R1: After synchronous reset the set is empty. No result is presented while reset is held. A query on any element then returns hit=0, and a locate returns hit=0.
- R2: Opcode encoding on `in_op`: 0 = insert, 1 = remove, 2 = query, 3 = locate. After an insert of element i, a query of i returns hit=1.
- R3: After a remove of element i, a query of i returns hit=0. Other members are unaffected.
- R4: For insert and remove, `out_hit` reports whether the element was a member just before that operation.
- R5: Inserting a member that is already present, or removing one that is absent, leaves the occupancy counts unchanged. For example, two inserts of i followed by one remove of i leave locate reporting an empty set.
- R6: Locate on a non-empty set returns hit=1 and the smallest member index in `out_idx`.
- R7: Locate on an empty set returns hit=0 with `out_idx` = 0.
- R8: Each accepted operation gives exactly one result. With `NUM_LEAF = NUM_ELEM/WORD_W`, the result appears after the clock edge that is log2(NUM_LEAF)+1 edges after the accepting edge. Results come in issue order, one per cycle, and echo the opcode on `out_op`.
- R9: Every operation observes the effect of all earlier operations, including those issued in the immediately preceding cycles.
- R10: For insert, remove and query, `out_idx` echoes the element index that was issued.
- R11: A locate issued directly behind inserts that are still in flight finds the smallest of those inserted members.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | An operation is offered this cycle |
| in_op | input | 2 | Opcode: 0 insert, 1 remove, 2 query, 3 locate |
| in_idx | input | log2(NUM_ELEM) | Element index 0..NUM_ELEM-1 (ignored for locate) |
| out_valid | output | 1 | A result is presented |
| out_op | output | 2 | Opcode of the operation this result belongs to |
| out_hit | output | 1 | Membership flag (pre-state for insert/remove/query, non-empty for locate) |
| out_idx | output | log2(NUM_ELEM) | Located member, or the echoed index |

## Verification
The bench builds the block with the default configuration: 128 elements and 16-bit leaf words. This gives eight leaves, three summary levels and four pipeline stages. That size is small enough to drive elements at both ends of the universe, at leaf boundaries, and on both sides of every tree level. It also makes it cheap to keep a full reference bitmap in the bench. A long pseudo-random phase, with indices bunched into a narrow window, puts operations on the same element into adjacent pipeline stages many times. This exercises the forwarding of pre-state and the interleaving of locate with in-flight updates.

// File: rtl/abt_pkg.sv
package abt_pkg;
    parameter int unsigned NUM_ELEM = 128;
    parameter int unsigned WORD_W   = 16;

    localparam int unsigned NUM_LEAF = NUM_ELEM / WORD_W;
    localparam int unsigned IDX_W    = $clog2(NUM_ELEM);
    localparam int unsigned BIT_W    = $clog2(WORD_W);
    localparam int unsigned LEV      = $clog2(NUM_LEAF);
    localparam int unsigned PATH_W   = IDX_W - BIT_W;
    localparam int unsigned CNT_W    = IDX_W;
    localparam int unsigned LATENCY  = LEV + 1;

    typedef enum logic [1:0] {
        OP_ADD  = 2'd0,
        OP_DEL  = 2'd1,
        OP_TEST = 2'd2,
        OP_FIND = 2'd3
    } op_e;

    // One pipeline slot travelling down the tree
    typedef struct packed {
        logic              vld;
        op_e               op;
        logic [IDX_W-1:0]  idx;
        logic [PATH_W-1:0] path;   // leaf number, built level by level for locate
        logic              pre;    // membership before this operation
        logic              empty;  // locate found nothing at the root
    } stage_t;

    typedef struct packed {
        logic             vld;
        op_e              op;
        logic             hit;
        logic [IDX_W-1:0] idx;
    } result_t;

    function automatic logic [BIT_W-1:0] low_bit(input logic [WORD_W-1:0] w);
        logic [BIT_W-1:0] p;
        p = '0;
        for (int b = WORD_W - 1; b >= 0; b--) begin
            if (w[b]) p = BIT_W'(b);
        end
        return p;
    endfunction

    // True when the slot flips its bit and so must adjust the counts
    function automatic logic flips(input stage_t s);
        return s.vld && ((s.op == OP_ADD && !s.pre) || (s.op == OP_DEL && s.pre));
    endfunction
endpackage

// File: rtl/abt_fwd.sv
module abt_fwd
    import abt_pkg::*;
(
    input  logic              in_valid,
    input  op_e               in_op,
    input  logic [IDX_W-1:0]  in_idx,
    input  stage_t            older [0:LEV],
    input  logic [WORD_W-1:0] leaf_word,
    output logic [PATH_W-1:0] leaf_sel,
    output stage_t            issue
);
    logic cur;

    always_comb begin
        leaf_sel = in_idx[IDX_W-1:BIT_W];
        cur      = leaf_word[in_idx[BIT_W-1:0]];
        // oldest first, so the youngest matching update wins
        for (int j = LEV; j >= 0; j--) begin
            if (older[j].vld && older[j].idx == in_idx &&
                (older[j].op == OP_ADD || older[j].op == OP_DEL)) begin
                cur = (older[j].op == OP_ADD);
            end
        end
        issue.vld   = in_valid;
        issue.op    = in_op;
        issue.idx   = in_idx;
        issue.path  = (in_op == OP_FIND) ? '0 : leaf_sel;
        issue.pre   = cur;
        issue.empty = 1'b0;
    end
endmodule

// File: rtl/abt_level.sv
module abt_level
    import abt_pkg::*;
#(
    parameter int unsigned K = 0
) (
    input  logic   clk,
    input  logic   rst,
    input  stage_t st_in,
    output stage_t st_out
);
    localparam int unsigned NODE_W = (K == 0) ? 1 : K;
    localparam int unsigned NODES  = 1 << NODE_W;
    localparam int unsigned DBIT   = LEV - 1 - K;

    logic [CNT_W-1:0] lcnt [NODES];
    logic [CNT_W-1:0] rcnt [NODES];
    logic [NODE_W-1:0] node;
    logic lzero, dir, wr;

    always_comb begin
        node  = NODE_W'(st_in.path >> (LEV - K));
        lzero = (lcnt[node] == '0);
        dir   = (st_in.op == OP_FIND) ? lzero : st_in.path[DBIT];
        wr    = flips(st_in);
        st_out = st_in;
        st_out.path[DBIT] = dir;
        if (K == 0 && st_in.op == OP_FIND) begin
            st_out.empty = lzero && (rcnt[node] == '0);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int n = 0; n < NODES; n++) begin
                lcnt[n] <= '0;
                rcnt[n] <= '0;
            end
        end else if (wr) begin
            if (!dir) begin
                lcnt[node] <= (st_in.op == OP_ADD) ? lcnt[node] + 1'b1 : lcnt[node] - 1'b1;
            end else begin
                rcnt[node] <= (st_in.op == OP_ADD) ? rcnt[node] + 1'b1 : rcnt[node] - 1'b1;
            end
        end
    end
endmodule

// File: rtl/abt_leaf.sv
module abt_leaf
    import abt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  stage_t            st_in,
    input  logic [PATH_W-1:0] q_sel,
    output logic [WORD_W-1:0] q_word,
    output result_t           res
);
    logic [WORD_W-1:0] words [NUM_LEAF];
    logic [WORD_W-1:0] cur;
    logic [BIT_W-1:0]  pos;

    always_comb begin
        q_word  = words[q_sel];
        cur     = words[st_in.path];
        pos     = low_bit(cur);
        res.vld = st_in.vld;
        res.op  = st_in.op;
        if (st_in.op == OP_FIND) begin
            res.hit = !st_in.empty;
            res.idx = st_in.empty ? '0 : {st_in.path, pos};
        end else begin
            res.hit = st_in.pre;
            res.idx = st_in.idx;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int n = 0; n < NUM_LEAF; n++) words[n] <= '0;
        end else if (flips(st_in)) begin
            words[st_in.path][st_in.idx[BIT_W-1:0]] <= (st_in.op == OP_ADD);
        end
    end
endmodule

// File: rtl/abt_set.sv
module abt_set
    import abt_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic [1:0]       in_op,
    input  logic [IDX_W-1:0] in_idx,
    output logic             out_valid,
    output logic [1:0]       out_op,
    output logic             out_hit,
    output logic [IDX_W-1:0] out_idx
);
    stage_t  st_q [0:LEV];
    stage_t  st_d [0:LEV];
    result_t res_d, res_q;
    logic [PATH_W-1:0] q_sel;
    logic [WORD_W-1:0] q_word;

    abt_fwd u_fwd (
        .in_valid  (in_valid),
        .in_op     (op_e'(in_op)),
        .in_idx    (in_idx),
        .older     (st_q),
        .leaf_word (q_word),
        .leaf_sel  (q_sel),
        .issue     (st_d[0])
    );

    for (genvar k = 0; k < LEV; k++) begin : g_lvl
        abt_level #(.K(k)) u_lvl (
            .clk    (clk),
            .rst    (rst),
            .st_in  (st_q[k]),
            .st_out (st_d[k+1])
        );
    end

    abt_leaf u_leaf (
        .clk    (clk),
        .rst    (rst),
        .st_in  (st_q[LEV]),
        .q_sel  (q_sel),
        .q_word (q_word),
        .res    (res_d)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int k = 0; k <= LEV; k++) st_q[k] <= '0;
            res_q <= '0;
        end else begin
            for (int k = 0; k <= LEV; k++) st_q[k] <= st_d[k];
            res_q <= res_d;
        end
    end

    assign out_valid = res_q.vld;
    assign out_op    = res_q.op;
    assign out_hit   = res_q.hit;
    assign out_idx   = res_q.idx;
endmodule

// File: rtl/abt_set_chk.sv
module abt_set_chk
    import abt_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             in_valid,
    input logic [1:0]       in_op,
    input logic [IDX_W-1:0] in_idx,
    input logic             out_valid,
    input logic [1:0]       out_op,
    input logic             out_hit,
    input logic [IDX_W-1:0] out_idx
);
    logic             hv   [0:LATENCY+1];
    logic [1:0]       hop  [0:LATENCY+1];
    logic [IDX_W-1:0] hidx [0:LATENCY+1];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int j = 0; j <= LATENCY + 1; j++) begin
                hv[j] <= 1'b0; hop[j] <= '0; hidx[j] <= '0;
            end
        end else begin
            hv[0] <= in_valid; hop[0] <= in_op; hidx[0] <= in_idx;
            for (int j = 1; j <= LATENCY + 1; j++) begin
                hv[j] <= hv[j-1]; hop[j] <= hop[j-1]; hidx[j] <= hidx[j-1];
            end
        end
    end

    AST_RESULT_TIMING: assert property (@(posedge clk) disable iff (rst)
        out_valid == hv[LATENCY]); // R8
    AST_OP_ORDER: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> out_op == hop[LATENCY]); // R8
    AST_IDX_ECHO: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_op != 2'd3) |-> out_idx == hidx[LATENCY]); // R10
    AST_BACK_TO_BACK: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_op == 2'd2 && hv[LATENCY+1] && hidx[LATENCY+1] == hidx[LATENCY]
         && hop[LATENCY+1][1] == 1'b0) |-> out_hit == (hop[LATENCY+1] == 2'd0)); // R9
    AST_EMPTY_LOCATE: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_op == 2'd3 && !out_hit) |-> out_idx == '0); // R7
endmodule

bind abt_set abt_set_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_op     (in_op),
    .in_idx    (in_idx),
    .out_valid (out_valid),
    .out_op    (out_op),
    .out_hit   (out_hit),
    .out_idx   (out_idx)
);

// File: tb/tb_abt_set.sv
module tb_abt_set;
    localparam int CLK_PERIOD = 10;
    localparam int N   = 128;
    localparam int W   = 16;
    localparam int LAT = $clog2(N / W) + 1;
    localparam int IW  = $clog2(N);

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          in_valid = 1'b0;
    logic [1:0]    in_op = '0;
    logic [IW-1:0] in_idx = '0;
    logic          out_valid;
    logic [1:0]    out_op;
    logic          out_hit;
    logic [IW-1:0] out_idx;

    always #(CLK_PERIOD / 2) clk = ~clk;

    abt_set dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_op(in_op), .in_idx(in_idx),
        .out_valid(out_valid), .out_op(out_op), .out_hit(out_hit), .out_idx(out_idx)
    );

    int total = 0;
    int bad   = 0;
    int cyc   = 0;
    bit model [N];
    bit monitor_on = 1'b0;

    logic [1:0]    q_op  [$];
    logic          q_hit [$];
    logic [IW-1:0] q_idx [$];
    int            q_cyc [$];
    string         q_tag [$];

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(bit ok, string tag, string act, string exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%s expected=%s", tag, act, exp);
        end
    endtask

    task automatic report();
        $display("  test done: total=%0d bad=%0d", total, bad);
    endtask

    // driver: offer one operation and record what must come back
    task automatic issue(int op, int idx, string tag);
        bit h;
        int e;
        @(negedge clk);
        in_valid = 1'b1;
        in_op    = 2'(op);
        in_idx   = IW'(idx);
        h = 1'b0;
        e = idx;
        case (op)
            0: begin h = model[idx]; model[idx] = 1'b1; end
            1: begin h = model[idx]; model[idx] = 1'b0; end
            2: h = model[idx];
            default: begin
                e = 0;
                for (int i = N - 1; i >= 0; i--) if (model[i]) begin h = 1'b1; e = i; end
            end
        endcase
        q_op.push_back(2'(op));
        q_hit.push_back(h);
        q_idx.push_back(IW'(e));
        q_cyc.push_back(cyc + 1 + LAT);
        q_tag.push_back(tag);
    endtask

    task automatic idle(int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            in_valid = 1'b0;
        end
    endtask

    // monitor: compare every result against the head of the scoreboard
    always @(negedge clk) begin
        if (monitor_on && out_valid) begin
            if (q_op.size() == 0) begin
                check(1'b0, "R8 spurious result", $sformatf("op=%0d", out_op), "none");
            end else begin
                logic [1:0]    eo;
                logic          eh;
                logic [IW-1:0] ei;
                int            ec;
                string         t;
                eo = q_op.pop_front(); eh = q_hit.pop_front(); ei = q_idx.pop_front();
                ec = q_cyc.pop_front(); t = q_tag.pop_front();
                check(out_op == eo && out_hit == eh && out_idx == ei && cyc == ec, t,
                      $sformatf("op=%0d hit=%0d idx=%0d cyc=%0d", out_op, out_hit, out_idx, cyc),
                      $sformatf("op=%0d hit=%0d idx=%0d cyc=%0d", eo, eh, ei, ec));
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog R8 actual=running expected=finished");
        report();
        $finish;
    end

    initial begin
        logic [15:0] lfsr;
        repeat (3) @(negedge clk);
        check(out_valid == 1'b0, "R1 reset output", $sformatf("%0d", out_valid), "0");
        @(negedge clk);
        rst = 1'b0;
        monitor_on = 1'b1;
        check(out_valid == 1'b0, "R1 idle after reset", $sformatf("%0d", out_valid), "0");

        issue(3, 0, "R1 locate on fresh set");
        issue(2, 5, "R1 query on fresh set");
        idle(6);

        issue(0, 37, "R4 insert reports absent");
        issue(2, 37, "R2 query right after insert");
        issue(0, 37, "R4 second insert reports present");
        issue(1, 37, "R4 remove reports present");
        issue(2, 37, "R3 query after remove");
        issue(3, 0, "R5 redundant insert left counts clean");
        idle(6);

        issue(0, 100, "R2 insert 100");
        issue(0, 17, "R2 insert 17");
        issue(0, 64, "R2 insert 64");
        issue(3, 0, "R11 locate behind in-flight inserts");
        issue(2, 64, "R10 query echoes index");
        issue(1, 17, "R3 remove 17");
        issue(3, 0, "R6 locate after removing smallest");
        idle(2);
        issue(0, 0, "R2 insert lowest element");
        issue(0, 127, "R2 insert highest element");
        issue(3, 0, "R6 locate finds element 0");
        issue(1, 0, "R3 remove 0");
        issue(1, 64, "R3 remove 64");
        issue(1, 100, "R3 remove 100");
        issue(3, 0, "R6 locate finds element 127");
        issue(2, 126, "R3 neighbour unaffected");
        issue(1, 127, "R4 remove 127");
        issue(1, 127, "R4 remove of absent element");
        issue(3, 0, "R7 locate on emptied set");
        idle(8);

        lfsr = 16'hACE1;
        for (int n = 0; n < 400; n++) begin
            int idx;
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            idx = lfsr[15] ? int'(lfsr[10:4]) : 60 + int'(lfsr[5:4]);
            if (lfsr[14:13] == 2'b00) idle(1);
            else issue(int'(lfsr[1:0]), idx, "R9 mixed stream");
        end
        idle(LAT + 4);
        check(q_op.size() == 0, "R8 all results returned",
              $sformatf("%0d", q_op.size()), "0");
        report();
        $finish;
    end
endmodule